// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder/Subtractor

This block adds or subtracts two 16-bit words in a single combinational pass. It produces the result, the unsigned carry out of the top bit, a signed two's-complement overflow flag, and a propagate/generate pair that summarises the whole word. A wider lookahead tree can use that pair to treat this block as one of its groups.

The word is split into four 4-bit groups. Each group builds its internal carries as flat two-level sums of products from per-bit generate (`a & b`) and propagate (`a ^ b`) terms. Each group also reports its own block propagate and block generate. A second-level unit applies the same carry equations to the four group pairs. It delivers the carry into every group and the final carry out directly from the external carry-in, so no carry ripples between groups.

Subtraction reuses the adder. When the subtract control is high, every bit of the second operand is inverted and the carry-in is forced to 1, which forms `A + ~B + 1`. The block has no storage, so results follow the inputs within the same cycle. A caller that wants a streaming interface wraps it in its own registers.

Top module: `cla_addsub16`

## Requirements
- R1: With `sub_en` = 0, `sum_out` equals (`a_in` + `b_in`) mod 2^16 and `carry_out` equals bit 16 of that unsigned sum.
- R2: With `sub_en` = 1, `sum_out` equals (`a_in` − `b_in`) mod 2^16 and `carry_out` is bit 16 of `a_in` + ~`b_in` + 1, that is 1 exactly when `a_in` ≥ `b_in` as unsigned numbers (no borrow).
- R3: With the effective operand E = `b_in` XOR {16{`sub_en`}}, `grp_prop_out` is 1 exactly when every bit of `a_in` differs from the matching bit of E, and `grp_gen_out` is 1 exactly when `a_in` + E with a zero carry-in carries out of bit 15.
- R4: `ovf_out` is 1 exactly when `a_in` and E have the same bit 15 and `sum_out` bit 15 differs from it. This equals the XOR of the carries into and out of bit 15.
- R5: 0xFFFF + 0x0001 (the longest carry chain) gives `sum_out` = 0x0000, `carry_out` = 1, `ovf_out` = 0, `grp_prop_out` = 0 and `grp_gen_out` = 1.
- R6: The signed boundary cases overflow. 0x7FFF + 0x0001 gives 0x8000 with `ovf_out` = 1 and `carry_out` = 0. 0x8000 − 0x0001 gives 0x7FFF with `ovf_out` = 1 and `carry_out` = 1.
- R7: Any value minus itself gives `sum_out` = 0, `carry_out` = 1, `ovf_out` = 0 and `grp_prop_out` = 1.
- R8: The block holds no state. For all-zero inputs with `sub_en` = 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand, inverted internally when subtracting |
| sub_en | input | 1 | 0 selects add, 1 selects subtract; also acts as the carry-in |
| sum_out | output | 16 | Result modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf_out | output | 1 | Two's-complement overflow |
| grp_prop_out | output | 1 | Whole-word propagate from the second-level unit |
| grp_gen_out | output | 1 | Whole-word generate from the second-level unit |

## Verification
Every output is a pure function of the current inputs and passes through no register, so each result is due in the same cycle as its operands. The bench applies operands just after a falling clock edge and samples all five results 1 ns later, well before the next rising edge. Each sample is therefore taken on settled logic and always matches the stimulus it checks. Expected values come from 17-bit behavioural arithmetic on the effective operand. The flag expectations are derived from that arithmetic and from the bitwise propagate rule.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int CLA_GROUP_W    = 4;
  localparam int CLA_NUM_GROUPS = 4;
  localparam int CLA_WIDTH      = CLA_GROUP_W * CLA_NUM_GROUPS;
endpackage

// File: rtl/cla_pg_gen.sv
module cla_pg_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {W{invert_b}};
    p     = a ^ b_eff;
    g     = a & b_eff;
  end

  // R3: a bit cannot both propagate and generate
  always_comb begin
    if (!$isunknown({a, b, invert_b})) begin
      a_r3_pg_exclusive: assert ((p & g) == '0)
        else $error("bit both propagates and generates");
    end
  end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N-1:0] c,
  output logic         cout,
  output logic         blk_p,
  output logic         blk_g
);
  logic [N:0] cy;

  // Each carry is an OR of independent product terms (flat two-level form).
  always_comb begin
    logic acc;
    logic prod;
    cy    = '0;
    cy[0] = cin;
    for (int i = 0; i < N; i++) begin
      acc = cin;
      for (int k = 0; k <= i; k++) acc = acc & p[k];
      for (int j = 0; j <= i; j++) begin
        prod = g[j];
        for (int k = j + 1; k <= i; k++) prod = prod & p[k];
        acc = acc | prod;
      end
      cy[i+1] = acc;
    end
  end

  always_comb begin
    logic prod;
    blk_p = &p;
    blk_g = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = g[j];
      for (int k = j + 1; k < N; k++) prod = prod & p[k];
      blk_g = blk_g | prod;
    end
  end

  assign c    = cy[N-1:0];
  assign cout = cy[N];

  always_comb begin
    if (!$isunknown({p, g, cin})) begin
      // R3: a propagating block passes its carry-in straight through
      a_r3_block_pass: assert (!blk_p || (cout == cin))
        else $error("propagating block altered carry");
      // R3: a generating block always carries out
      a_r3_block_gen: assert (!blk_g || cout)
        else $error("generating block without carry");
      // R3: a block that neither propagates nor generates kills the carry
      a_r3_block_kill: assert (blk_p || blk_g || !cout)
        else $error("killed block produced carry");
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] p,
  input  logic [GW-1:0] g,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          msb_cin,
  output logic          cout,
  output logic          gp,
  output logic          gg
);
  logic [GW-1:0] cvec;

  cla_carry_unit #(.N(GW)) u_carry (
    .p     (p),
    .g     (g),
    .cin   (cin),
    .c     (cvec),
    .cout  (cout),
    .blk_p (gp),
    .blk_g (gg)
  );

  assign sum     = p ^ cvec;
  assign msb_cin = cvec[GW-1];
endmodule

// File: rtl/cla_addsub16.sv
module cla_addsub16
  import cla_pkg::*;
#(
  parameter int GROUP_W    = CLA_GROUP_W,
  parameter int NUM_GROUPS = CLA_NUM_GROUPS
) (
  input  logic [GROUP_W*NUM_GROUPS-1:0] a_in,
  input  logic [GROUP_W*NUM_GROUPS-1:0] b_in,
  input  logic                          sub_en,
  output logic [GROUP_W*NUM_GROUPS-1:0] sum_out,
  output logic                          carry_out,
  output logic                          ovf_out,
  output logic                          grp_prop_out,
  output logic                          grp_gen_out
);
  localparam int W = GROUP_W * NUM_GROUPS;

  logic [W-1:0]          bit_p;
  logic [W-1:0]          bit_g;
  logic [NUM_GROUPS-1:0] grp_p;
  logic [NUM_GROUPS-1:0] grp_g;
  logic [NUM_GROUPS-1:0] grp_cin;
  logic [NUM_GROUPS-1:0] grp_cout;
  logic [NUM_GROUPS-1:0] grp_msb_cin;

  cla_pg_gen #(.W(W)) u_pg (
    .a        (a_in),
    .b        (b_in),
    .invert_b (sub_en),
    .p        (bit_p),
    .g        (bit_g)
  );

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
    cla_group #(.GW(GROUP_W)) u_group (
      .p       (bit_p[gi*GROUP_W +: GROUP_W]),
      .g       (bit_g[gi*GROUP_W +: GROUP_W]),
      .cin     (grp_cin[gi]),
      .sum     (sum_out[gi*GROUP_W +: GROUP_W]),
      .msb_cin (grp_msb_cin[gi]),
      .cout    (grp_cout[gi]),
      .gp      (grp_p[gi]),
      .gg      (grp_g[gi])
    );
  end

  // Second-level lookahead: group carry-ins and final carry from sub_en only.
  cla_carry_unit #(.N(NUM_GROUPS)) u_level2 (
    .p     (grp_p),
    .g     (grp_g),
    .cin   (sub_en),
    .c     (grp_cin),
    .cout  (carry_out),
    .blk_p (grp_prop_out),
    .blk_g (grp_gen_out)
  );

  assign ovf_out = grp_msb_cin[NUM_GROUPS-1] ^ carry_out;

  always_comb begin
    logic [W:0]   ref_sum;
    logic [W-1:0] b_eff;
    b_eff   = b_in ^ {W{sub_en}};
    ref_sum = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
    if (!$isunknown({a_in, b_in, sub_en})) begin
      // R1 / R2: word result and carry agree with plain arithmetic
      a_r1_sum_exact: assert ({carry_out, sum_out} == ref_sum)
        else $error("sum mismatch");
      // R4: overflow only for like-signed operands with an opposite-signed result
      a_r4_ovf_signs: assert (ovf_out == ((a_in[W-1] == b_eff[W-1]) &&
                                          (sum_out[W-1] != a_in[W-1])))
        else $error("overflow flag mismatch");
      // R3: group carry-outs agree with the second-level carries
      a_r3_group_carry_agree: assert (grp_cout == {carry_out, grp_cin[NUM_GROUPS-1:1]})
        else $error("group carry disagrees with level-two carry");
    end
  end
endmodule

// File: tb/tb_cla_addsub16.sv
`timescale 1ns/1ps
module tb_cla_addsub16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic        sub_en = 1'b0;
  logic [15:0] sum_out;
  logic        carry_out, ovf_out, grp_prop_out, grp_gen_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cla_addsub16 dut (
    .a_in         (a_in),
    .b_in         (b_in),
    .sub_en       (sub_en),
    .sum_out      (sum_out),
    .carry_out    (carry_out),
    .ovf_out      (ovf_out),
    .grp_prop_out (grp_prop_out),
    .grp_gen_out  (grp_gen_out)
  );

  task automatic cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive after the falling edge, sample 1 ns later on settled logic.
  task automatic apply(logic [15:0] a, logic [15:0] b, logic s);
    @(negedge clk);
    a_in = a; b_in = b; sub_en = s;
    #1;
  endtask

  task automatic check_model(string req, logic [15:0] a, logic [15:0] b, logic s);
    logic [15:0] e;
    logic [16:0] full;
    logic [16:0] plain;
    apply(a, b, s);
    e     = s ? ~b : b;
    full  = {1'b0, a} + {1'b0, e} + {16'd0, s};
    plain = {1'b0, a} + {1'b0, e};
    cmp(req, "sum", sum_out, full[15:0]);
    cmp(req, "carry", {15'd0, carry_out}, {15'd0, full[16]});
    cmp("R4", "ovf", {15'd0, ovf_out},
        {15'd0, (a[15] == e[15]) && (full[15] != a[15])});
    cmp("R3", "prop", {15'd0, grp_prop_out}, {15'd0, (a ^ e) == 16'hFFFF});
    cmp("R3", "gen", {15'd0, grp_gen_out}, {15'd0, plain[16]});
  endtask

  task automatic t_reset_state();  // R8
    apply(16'h0000, 16'h0000, 1'b0);
    cmp("R8", "sum", sum_out, 16'h0000);
    cmp("R8", "flags", {11'd0, carry_out, ovf_out, grp_prop_out, grp_gen_out, 1'b0}, 16'h0000);
  endtask

  task automatic t_worst_carry();  // R5
    apply(16'hFFFF, 16'h0001, 1'b0);
    cmp("R5", "sum", sum_out, 16'h0000);
    cmp("R5", "carry", {15'd0, carry_out}, 16'd1);
    cmp("R5", "ovf", {15'd0, ovf_out}, 16'd0);
    cmp("R5", "prop", {15'd0, grp_prop_out}, 16'd0);
    cmp("R5", "gen", {15'd0, grp_gen_out}, 16'd1);
  endtask

  task automatic t_signed_edges();  // R6
    apply(16'h7FFF, 16'h0001, 1'b0);
    cmp("R6", "sum", sum_out, 16'h8000);
    cmp("R6", "ovf", {15'd0, ovf_out}, 16'd1);
    cmp("R6", "carry", {15'd0, carry_out}, 16'd0);
    apply(16'h8000, 16'h0001, 1'b1);
    cmp("R6", "sum", sum_out, 16'h7FFF);
    cmp("R6", "ovf", {15'd0, ovf_out}, 16'd1);
    cmp("R6", "carry", {15'd0, carry_out}, 16'd1);
  endtask

  task automatic t_self_sub();  // R7
    logic [15:0] vals [4] = '{16'h0000, 16'h1234, 16'h8000, 16'hFFFF};
    foreach (vals[i]) begin
      apply(vals[i], vals[i], 1'b1);
      cmp("R7", "sum", sum_out, 16'h0000);
      cmp("R7", "carry", {15'd0, carry_out}, 16'd1);
      cmp("R7", "ovf", {15'd0, ovf_out}, 16'd0);
      cmp("R7", "prop", {15'd0, grp_prop_out}, 16'd1);
    end
  endtask

  task automatic t_add_patterns();  // R1
    check_model("R1", 16'h000F, 16'h0001, 1'b0);
    check_model("R1", 16'h0FFF, 16'h0001, 1'b0);
    check_model("R1", 16'hAAAA, 16'h5555, 1'b0);
    check_model("R1", 16'h8000, 16'h8000, 1'b0);
    check_model("R1", 16'hF0F0, 16'h0F10, 1'b0);
    for (int i = 0; i < 200; i++) check_model("R1", 16'($urandom), 16'($urandom), 1'b0);
  endtask

  task automatic t_sub_patterns();  // R2
    check_model("R2", 16'h0000, 16'h0001, 1'b1);
    check_model("R2", 16'h0001, 16'h0000, 1'b1);
    check_model("R2", 16'h7FFF, 16'hFFFF, 1'b1);
    check_model("R2", 16'h1000, 16'h0001, 1'b1);
    for (int i = 0; i < 200; i++) check_model("R2", 16'($urandom), 16'($urandom), 1'b1);
  endtask

  task automatic t_sub_borrow();  // R2: carry_out is the no-borrow flag
    apply(16'h0003, 16'h0005, 1'b1);
    cmp("R2", "borrow", {15'd0, carry_out}, 16'd0);
    cmp("R2", "sum", sum_out, 16'hFFFE);
    apply(16'h0005, 16'h0003, 1'b1);
    cmp("R2", "noborrow", {15'd0, carry_out}, 16'd1);
    cmp("R2", "sum", sum_out, 16'h0002);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_worst_carry();
    t_signed_edges();
    t_self_sub();
    t_add_patterns();
    t_sub_patterns();
    t_sub_borrow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule